// File: doc/BRIEF.md
# APB Configuration Register Bank with Enable-Based Writes

This block is an APB slave holding a parameterised number of 32-bit configuration words. It suits FPGA targets: every storage flop runs on the free-running bus clock, and no derived or gated register clock exists anywhere in the design. A write is recognised while the transfer is in its setup phase. That indication, with the word address, is captured on the falling edge of the bus clock. The captured pulse then acts as a synchronous load enable for the addressed word at the rising edge that opens the access phase.

Reads are served from the same words. The read data is registered at the end of the setup phase, so it is stable for the whole access phase. The slave never inserts wait states. Apart from a configuration write, every stored word keeps its value, which is the same result a stopped register clock would give.

Top module: `cfg_regbank`

## Requirements
- R1: While `apb_rst_n` is low, every stored word, the held write indication and `apb_rdata` are 0 (asynchronous clear). After reset is released, every word reads back as 0.
- R2: A write transfer loads `apb_wdata` into word number `apb_addr[ADDR_W-1:2]` at the rising edge that starts the access phase. A write transfer is `apb_sel`=1, `apb_write`=1 and `apb_enable`=0 at the falling edge inside the setup cycle.
- R3: A word that is not the target of a write keeps its value. A read transfer never changes any word.
- R4: Address bits `[1:0]` are ignored for both reads and writes.
- R5: A write whose word number is `NUM_REGS` or larger changes no stored word.
- R6: During the access phase of a read, `apb_rdata` holds the addressed word. For a word number of `NUM_REGS` or larger it holds 0.
- R7: `apb_ready` is always 1.
- R8: Back-to-back writes with no idle cycle between them each update exactly their own word.
- R9: No word loads at any edge that ends an access phase. This holds even when the access phase is held longer and `apb_wdata` changes after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| apb_clk | input | 1 | Free-running bus clock; all storage uses it |
| apb_rst_n | input | 1 | Asynchronous active-low reset |
| apb_sel | input | 1 | Slave select |
| apb_enable | input | 1 | High in the access phase |
| apb_write | input | 1 | 1 = write transfer, 0 = read transfer |
| apb_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| apb_wdata | input | DATA_W | Write data |
| apb_rdata | output | DATA_W | Registered read data |
| apb_ready | output | 1 | Constant 1 (no wait states) |

## Verification
Internal state is visible only through reads, so a fault in the stored words or the held write pulse appears at the next read of the affected word. That read is the access cycle that follows its setup cycle. A held pulse that stays high for one edge too long would overwrite the word with late data, and R9 forces that case. A decode fault lands data in the wrong word. The bench reads every word after each scenario, so the error shows within one sweep.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } bus_phase_e;

  function automatic bus_phase_e phase_of(input logic sel, input logic enable);
    if (!sel)        return PH_IDLE;
    else if (!enable) return PH_SETUP;
    else             return PH_ACCESS;
  endfunction

endpackage

// File: rtl/cfg_setup_capture.sv
module cfg_setup_capture #(
  parameter int WIDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_setup,
  input  logic [WIDX_W-1:0] word_in,
  output logic              wr_hold,
  output logic [WIDX_W-1:0] word_hold
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold   <= 1'b0;
      word_hold <= '0;
    end else begin
      wr_hold <= wr_setup;
      if (wr_setup) begin
        word_hold <= word_in;
      end
    end
  end

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int WIDX_W   = 10,
  parameter int NUM_REGS = 8
) (
  input  logic [WIDX_W-1:0]   word,
  output logic [NUM_REGS-1:0] onehot
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign onehot[i] = (word == WIDX_W'(i));
  end

endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              load_en,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (load_en[i]) begin
        q[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_setup,
  input  logic [NUM_REGS-1:0]             pick,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]               rdata
);

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      picked = picked | (words[i] & {DATA_W{pick[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_setup) begin
      rdata <= picked;
    end
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12
) (
  input  logic              apb_clk,
  input  logic              apb_rst_n,
  input  logic              apb_sel,
  input  logic              apb_enable,
  input  logic              apb_write,
  input  logic [ADDR_W-1:0] apb_addr,
  input  logic [DATA_W-1:0] apb_wdata,
  output logic [DATA_W-1:0] apb_rdata,
  output logic              apb_ready
);
  import cfgbank_pkg::*;

  localparam int WIDX_W = ADDR_W - 2;

  bus_phase_e                      phase;
  logic                            wr_setup;
  logic                            rd_setup;
  logic [WIDX_W-1:0]               word_now;
  logic                            wr_hold;
  logic [WIDX_W-1:0]               word_hold;
  logic [NUM_REGS-1:0]             wr_pick;
  logic [NUM_REGS-1:0]             rd_pick;
  logic [NUM_REGS-1:0]             load_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [1:0]                      addr_lsb_unused;

  assign phase           = phase_of(apb_sel, apb_enable);
  assign wr_setup        = (phase == PH_SETUP) && apb_write;
  assign rd_setup        = (phase == PH_SETUP) && !apb_write;
  assign word_now        = apb_addr[ADDR_W-1:2];
  assign addr_lsb_unused = apb_addr[1:0];
  assign apb_ready       = 1'b1;

  cfg_setup_capture #(.WIDX_W(WIDX_W)) u_capture (
    .clk       (apb_clk),
    .rst_n     (apb_rst_n),
    .wr_setup  (wr_setup),
    .word_in   (word_now),
    .wr_hold   (wr_hold),
    .word_hold (word_hold)
  );

  cfg_addr_decode #(.WIDX_W(WIDX_W), .NUM_REGS(NUM_REGS)) u_wr_dec (
    .word   (word_hold),
    .onehot (wr_pick)
  );

  cfg_addr_decode #(.WIDX_W(WIDX_W), .NUM_REGS(NUM_REGS)) u_rd_dec (
    .word   (word_now),
    .onehot (rd_pick)
  );

  assign load_en = wr_pick & {NUM_REGS{wr_hold}};

  cfg_reg_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk     (apb_clk),
    .rst_n   (apb_rst_n),
    .load_en (load_en),
    .wdata   (apb_wdata),
    .q       (reg_q)
  );

  cfg_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .clk      (apb_clk),
    .rst_n    (apb_rst_n),
    .rd_setup (rd_setup),
    .pick     (rd_pick),
    .words    (reg_q),
    .rdata    (apb_rdata)
  );

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sel,
  input logic                            enable,
  input logic                            write,
  input logic [ADDR_W-1:0]               addr,
  input logic [DATA_W-1:0]               wdata,
  input logic [DATA_W-1:0]               rdata,
  input logic                            ready,
  input logic                            wr_hold,
  input logic [ADDR_W-3:0]               word_hold,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             hold_mapped;
  logic             addr_mapped;
  logic [IDX_W-1:0] hold_idx;

  assign hold_mapped = (int'(word_hold) < NUM_REGS);
  assign addr_mapped = (int'(addr[ADDR_W-1:2]) < NUM_REGS);
  assign hold_idx    = word_hold[IDX_W-1:0];

  // R7
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready == 1'b1);

  // R2
  write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold && hold_mapped |=> regs[$past(hold_idx)] == $past(wdata));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hold |=> $stable(regs));

  // R5
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold && !hold_mapped |=> $stable(regs));

  // R6
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !enable && !write && !addr_mapped |=> rdata == '0);

  // R9
  access_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && enable |-> !wr_hold);

endmodule

bind cfg_regbank cfg_regbank_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (apb_clk),
  .rst_n     (apb_rst_n),
  .sel       (apb_sel),
  .enable    (apb_enable),
  .write     (apb_write),
  .addr      (apb_addr),
  .wdata     (apb_wdata),
  .rdata     (apb_rdata),
  .ready     (apb_ready),
  .wr_hold   (wr_hold),
  .word_hold (word_hold),
  .regs      (reg_q)
);

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
  localparam int NUM_REGS = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam time CLK_P   = 20ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel = 1'b0;
  logic              en = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cfg_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .apb_clk    (clk),
    .apb_rst_n  (rst_n),
    .apb_sel    (sel),
    .apb_enable (en),
    .apb_write  (wr),
    .apb_addr   (addr),
    .apb_wdata  (wdata),
    .apb_rdata  (rdata),
    .apb_ready  (ready)
  );

  // behavioural reference model
  logic [DATA_W-1:0] model [NUM_REGS];
  logic [DATA_W-1:0] exp_rdata = '0;
  bit                pend = 1'b0;
  int                pend_word = 0;

  task automatic clear_model();
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    exp_rdata = '0;
    pend = 1'b0;
  endtask

  always @(negedge rst_n) clear_model();

  always @(negedge clk) begin
    if (!rst_n) pend = 1'b0;
    else begin
      pend = sel && wr && !en;
      if (pend) pend_word = int'(addr >> 2);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) clear_model();
    else begin
      if (pend && pend_word < NUM_REGS) model[pend_word] = wdata;
      if (sel && !en && !wr) begin
        if (int'(addr >> 2) < NUM_REGS) exp_rdata = model[int'(addr >> 2)];
        else exp_rdata = '0;
      end
    end
  end

  task automatic chk(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edges (R6 R7)
  always @(posedge clk) begin
    #(CLK_P*3/4);
    if (!done) begin
      chk("R7 ready", {31'd0, ready}, 32'd1);
      chk("R6 cycle rdata", rdata, exp_rdata);
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    sel = 1'b1; wr = 1'b1; en = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1;
    en = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    sel = 1'b1; wr = 1'b0; en = 1'b0; addr = a;
    @(posedge clk); #1;
    en = 1'b1;
    #(CLK_P/2);
    d = rdata;
    @(posedge clk); #1;
  endtask

  task automatic bus_idle();
    sel = 1'b0; en = 1'b0; wr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic sweep(input string req);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < NUM_REGS; i++) begin
      bus_read(ADDR_W'(i*4), d);
      chk(req, d, model[i]);
    end
    bus_idle();
  endtask

  initial begin
    #(CLK_P*200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    #(CLK_P*2 + 5ns);
    chk("R1 rdata in reset", rdata, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: every word reads zero after reset
    for (int i = 0; i < NUM_REGS; i++) begin
      bus_read(ADDR_W'(i*4), d);
      chk("R1 word after reset", d, '0);
    end
    bus_idle();

    // R2: fill every word, read back against literal pattern
    for (int i = 0; i < NUM_REGS; i++) begin
      bus_write(ADDR_W'(i*4), 32'h1000_0000 + 32'(i*17));
      bus_idle();
    end
    for (int i = 0; i < NUM_REGS; i++) begin
      bus_read(ADDR_W'(i*4), d);
      chk("R2 written word", d, 32'h1000_0000 + 32'(i*17));
    end
    bus_idle();

    // R4: low address bits ignored
    bus_write(ADDR_W'(2*4 + 3), 32'hCAFE_0002);
    bus_idle();
    bus_read(ADDR_W'(2*4 + 1), d);
    chk("R4 low bits ignored", d, 32'hCAFE_0002);
    bus_idle();

    // R5 / R6: unmapped write and read
    bus_write(ADDR_W'(NUM_REGS*4), 32'hDEAD_BEEF);
    bus_idle();
    bus_read(ADDR_W'(NUM_REGS*4), d);
    chk("R6 unmapped read zero", d, '0);
    bus_idle();
    bus_read(ADDR_W'(0), d);
    chk("R5 word0 untouched", d, 32'h1000_0000);
    sweep("R5 sweep after unmapped write");

    // R8: back-to-back writes
    bus_write(ADDR_W'(0), 32'hAAAA_0000);
    bus_write(ADDR_W'(4), 32'hBBBB_0001);
    bus_write(ADDR_W'(8), 32'hCCCC_0002);
    bus_idle();
    bus_read(ADDR_W'(0), d); chk("R8 b2b word0", d, 32'hAAAA_0000);
    bus_read(ADDR_W'(4), d); chk("R8 b2b word1", d, 32'hBBBB_0001);
    bus_read(ADDR_W'(8), d); chk("R8 b2b word2", d, 32'hCCCC_0002);
    bus_read(ADDR_W'(12), d); chk("R8 word3 kept", d, 32'h1000_0000 + 32'd51);
    bus_idle();

    // R3: repeated reads never alter a word
    for (int k = 0; k < 4; k++) begin
      bus_read(ADDR_W'(5*4), d);
      chk("R3 read leaves word", d, 32'h1000_0000 + 32'd85);
    end
    bus_idle();

    // R9: stretched access phase with late data change
    sel = 1'b1; wr = 1'b1; en = 1'b0; addr = ADDR_W'(6*4); wdata = 32'h0000_6666;
    @(posedge clk); #1;
    en = 1'b1; wdata = 32'hFFFF_9999;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_idle();
    bus_read(ADDR_W'(6*4), d);
    chk("R9 no load in access", d, 32'h0000_6666);
    bus_idle();
    sweep("R3 sweep");

    // R1: reset mid-run
    rst_n = 1'b0;
    #5ns;
    chk("R1 rdata async clear", rdata, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < NUM_REGS; i++) begin
      bus_read(ADDR_W'(i*4), d);
      chk("R1 word after second reset", d, '0);
    end
    bus_idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule